// File: doc/BRIEF.md
# Timing Generator and Instruction Fetch Control

This block is the front end of a hardwired controller for a small accumulator machine with 16-bit words and 12-bit addresses. A free-running 4-bit step counter is decoded into sixteen one-hot slot signals. The controller uses the first two slots to fetch an instruction. In the first slot it places the program counter on the internal bus and loads the address register from it. In the second slot it puts the memory word on the bus, loads it into the instruction register and advances the program counter.

The instruction register is split for the downstream execute logic. The three bits below the top bit are decoded into eight one-hot operation lines. The top bit is the indirect-addressing flag. The low twelve bits are the address field. The execute logic ends each instruction through a clear input, which returns the step counter to slot 0 on the next edge. Execution microoperations are outside this block.

Top module: `timing_fetch_ctl`

## Requirements
- R1: While rst_ni is low, the step counter is 0, so t_o = 16'h0001. The program counter, address register and instruction register are all 0, so d_o = 8'h01 and ind_o = 0.
- R2: t_o always has exactly one bit set, at the position equal to the step count. When sc_clr_i is low, the count rises by one on every clock edge.
- R3: If sc_clr_i is low during slot 15, the next slot is slot 0.
- R4: If sc_clr_i is high during a cycle, the next cycle is slot 0, whatever the current slot. This includes slot 0 itself.
- R5: In slot 0:
  - bus_sel_o = 3'b010, bus_o = {4'b0, pc_o} and ar_ld_o = 1.
  - mem_rd_o, ir_ld_o and pc_inc_o are 0.
  - The edge that ends the slot copies pc_o into ar_o.
- R6: In slot 1:
  - bus_sel_o = 3'b111, bus_o = mem_data_i, and mem_rd_o, ir_ld_o and pc_inc_o are 1.
  - ar_ld_o is 0.
  - The edge that ends the slot loads mem_data_i into ir_o and adds one to pc_o.
- R7: In slots 2 to 15, every control output is 0 and bus_sel_o = 3'b000. The program counter, address register and instruction register hold their values.
- R8: d_o is one-hot, with bit n set where n = ir_o[14:12].
- R9: ind_o equals bit 15 of the last fetched word, and addr_field_o equals ir_o[11:0].
- R10: The program counter is 12 bits wide and wraps from 12'hFFF to 12'h000 on an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sc_clr_i | input | 1 | Clear the step counter; the next slot is 0 |
| mem_data_i | input | 16 | Memory read data |
| t_o | output | 16 | One-hot timing slots T0..T15 |
| d_o | output | 8 | One-hot operation decode D0..D7 |
| ind_o | output | 1 | Indirect-addressing flag |
| addr_field_o | output | 12 | Address field of the instruction |
| bus_sel_o | output | 3 | Bus source select |
| bus_o | output | 16 | Internal bus value |
| ar_ld_o | output | 1 | Address register load |
| ir_ld_o | output | 1 | Instruction register load |
| mem_rd_o | output | 1 | Memory read strobe |
| pc_inc_o | output | 1 | Program counter increment |
| ar_o | output | 12 | Address register |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Instruction register |

## Verification
The bench steps through all sixteen slots and into the wrap. A counter that saturates, or that skips slot 0 after slot 15, would show up as a wrong slot there. It clears the counter in slot 1, where a design that let the increment win would move to slot 2. It also clears in slot 0, where a wrong design would go on to slot 1. Eight instruction words cover every opcode and both values of the indirect bit, which exposes a decoder wired to the wrong bits. A run of about 4096 fetches drives the program counter through its wrap, and an asynchronous reset is applied in mid-instruction. A counter that is too wide would fail the wrap, and registers that escape the reset would fail the reset check.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned SC_W   = 4;
  localparam int unsigned OP_W   = WORD_W - 1 - ADDR_W;

  typedef enum logic [2:0] {
    BUS_NONE = 3'b000,
    BUS_PC   = 3'b010,
    BUS_MEM  = 3'b111
  } bus_sel_e;
endpackage

// File: rtl/step_counter.sv
module step_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;  // natural wrap at CNT_MAX
  end

  assign cnt_o = cnt_q;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q == CNT_MAX) |=> cnt_q == '0);
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/onehot_decoder.sv
module onehot_decoder #(
  parameter int unsigned IN_W = 3
) (
  input  logic [IN_W-1:0]       code_i,
  output logic [(1<<IN_W)-1:0]  line_o
);
  localparam int unsigned N = 1 << IN_W;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign line_o[i] = (code_i == IN_W'(i));
  end

  always_comb begin
    a_r2_r8_onehot: assert ($countones(line_o) == 1);
  end
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
  import fetch_ctl_pkg::*;
(
  input  logic       slot0_i,
  input  logic       slot1_i,
  output logic [2:0] bus_sel_o,
  output logic       ar_ld_o,
  output logic       ir_ld_o,
  output logic       mem_rd_o,
  output logic       pc_inc_o
);
  always_comb begin
    bus_sel_o = BUS_NONE;
    ar_ld_o   = 1'b0;
    ir_ld_o   = 1'b0;
    mem_rd_o  = 1'b0;
    pc_inc_o  = 1'b0;
    if (slot0_i) begin
      bus_sel_o = BUS_PC;
      ar_ld_o   = 1'b1;
    end else if (slot1_i) begin
      bus_sel_o = BUS_MEM;
      mem_rd_o  = 1'b1;
      ir_ld_o   = 1'b1;
      pc_inc_o  = 1'b1;
    end
  end
endmodule

// File: rtl/fetch_regs.sv
module fetch_regs #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] bus_i,
  input  logic              ar_ld_i,
  input  logic              ir_ld_i,
  input  logic              pc_inc_i,
  output logic [ADDR_W-1:0] ar_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [WORD_W-1:0] ir_o,
  output logic              ind_o
);
  logic [ADDR_W-1:0] ar_q, pc_q;
  logic [WORD_W-1:0] ir_q;
  logic              ind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q  <= '0;
      pc_q  <= '0;
      ir_q  <= '0;
      ind_q <= 1'b0;
    end else begin
      if (ar_ld_i)  ar_q <= bus_i[ADDR_W-1:0];
      if (pc_inc_i) pc_q <= pc_q + 1'b1;
      if (ir_ld_i) begin
        ir_q  <= bus_i;
        ind_q <= bus_i[WORD_W-1];
      end
    end
  end

  assign ar_o  = ar_q;
  assign pc_o  = pc_q;
  assign ir_o  = ir_q;
  assign ind_o = ind_q;

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ar_ld_i || ir_ld_i || pc_inc_i) |=> ($stable(ar_q) && $stable(pc_q) && $stable(ir_q)));
  a_r10_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_i |=> pc_q == $past(pc_q) + 1'b1);
endmodule

// File: rtl/timing_fetch_ctl.sv
module timing_fetch_ctl
  import fetch_ctl_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sc_clr_i,
  input  logic [WORD_W-1:0]      mem_data_i,
  output logic [(1<<SC_W)-1:0]   t_o,
  output logic [(1<<OP_W)-1:0]   d_o,
  output logic                   ind_o,
  output logic [ADDR_W-1:0]      addr_field_o,
  output logic [2:0]             bus_sel_o,
  output logic [WORD_W-1:0]      bus_o,
  output logic                   ar_ld_o,
  output logic                   ir_ld_o,
  output logic                   mem_rd_o,
  output logic                   pc_inc_o,
  output logic [ADDR_W-1:0]      ar_o,
  output logic [ADDR_W-1:0]      pc_o,
  output logic [WORD_W-1:0]      ir_o
);
  logic [SC_W-1:0]   step;
  logic [ADDR_W-1:0] pc, ar;
  logic [WORD_W-1:0] ir;

  step_counter #(.W(SC_W)) u_sc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sc_clr_i),
    .cnt_o (step)
  );

  onehot_decoder #(.IN_W(SC_W)) u_tdec (
    .code_i(step),
    .line_o(t_o)
  );

  fetch_sequencer u_seq (
    .slot0_i  (t_o[0]),
    .slot1_i  (t_o[1]),
    .bus_sel_o(bus_sel_o),
    .ar_ld_o  (ar_ld_o),
    .ir_ld_o  (ir_ld_o),
    .mem_rd_o (mem_rd_o),
    .pc_inc_o (pc_inc_o)
  );

  always_comb begin
    unique case (bus_sel_o)
      BUS_PC:  bus_o = {{(WORD_W-ADDR_W){1'b0}}, pc};
      BUS_MEM: bus_o = mem_data_i;
      default: bus_o = '0;
    endcase
  end

  fetch_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bus_i   (bus_o),
    .ar_ld_i (ar_ld_o),
    .ir_ld_i (ir_ld_o),
    .pc_inc_i(pc_inc_o),
    .ar_o    (ar),
    .pc_o    (pc),
    .ir_o    (ir),
    .ind_o   (ind_o)
  );

  onehot_decoder #(.IN_W(OP_W)) u_ddec (
    .code_i(ir[WORD_W-2 -: OP_W]),
    .line_o(d_o)
  );

  assign ar_o         = ar;
  assign pc_o         = pc;
  assign ir_o         = ir;
  assign addr_field_o = ir[ADDR_W-1:0];

  a_r5_slot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[0] |-> (bus_sel_o == 3'b010 && ar_ld_o && !mem_rd_o && !ir_ld_o && !pc_inc_o));
  a_r5_ar_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[0] |=> ar == $past(pc));
  a_r6_slot1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[1] |-> (bus_sel_o == 3'b111 && mem_rd_o && ir_ld_o && pc_inc_o && !ar_ld_o));
  a_r6_ir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[1] |=> ir == $past(mem_data_i));
  a_r7_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(t_o[0] || t_o[1]) |-> (bus_sel_o == 3'b000 && !ar_ld_o && !ir_ld_o && !mem_rd_o && !pc_inc_o));
  a_r9_ind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_ld_o |=> ind_o == $past(mem_data_i[WORD_W-1]));
endmodule

// File: tb/tb_timing_fetch_ctl.sv
module tb_timing_fetch_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sc_clr = 1'b0;
  logic [15:0] mem = '0;
  logic [15:0] t_o, bus_o, ir_o;
  logic [7:0]  d_o;
  logic        ind_o, ar_ld, ir_ld, mem_rd, pc_inc;
  logic [11:0] addr_o, ar_o, pc_o;
  logic [2:0]  sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [11:0] exp_pc;
  logic [15:0] exp_ir;

  always #4 clk = ~clk;  // 125 MHz

  timing_fetch_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .sc_clr_i(sc_clr), .mem_data_i(mem),
    .t_o(t_o), .d_o(d_o), .ind_o(ind_o), .addr_field_o(addr_o),
    .bus_sel_o(sel), .bus_o(bus_o), .ar_ld_o(ar_ld), .ir_ld_o(ir_ld),
    .mem_rd_o(mem_rd), .pc_inc_o(pc_inc), .ar_o(ar_o), .pc_o(pc_o), .ir_o(ir_o)
  );

  // {word, expected d_o, expected ind, expected address field}
  localparam logic [36:0] VEC [8] = '{
    {16'h0ABC, 8'h01, 1'b0, 12'hABC},
    {16'h9123, 8'h02, 1'b1, 12'h123},
    {16'h2FFF, 8'h04, 1'b0, 12'hFFF},
    {16'hB000, 8'h08, 1'b1, 12'h000},
    {16'h4555, 8'h10, 1'b0, 12'h555},
    {16'hD00F, 8'h20, 1'b1, 12'h00F},
    {16'h6789, 8'h40, 1'b0, 12'h789},
    {16'hF001, 8'h80, 1'b1, 12'h001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctl_idle(input string req);
    check(req, {28'h0, ar_ld, ir_ld, mem_rd, pc_inc}, 32'h0);
    check(req, {29'h0, sel}, 32'h0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    check("R1 t", t_o, 32'h1);
    check("R1 pc", pc_o, 0);
    check("R1 ar", ar_o, 0);
    check("R1 ir", ir_o, 0);
    check("R1 d", d_o, 32'h1);
    check("R1 ind", ind_o, 0);
    mem = 16'hA123;
    rst_n = 1'b1;
    exp_pc = '0;
    exp_ir = '0;

    // free run over all slots and the wrap (R2, R3, R5, R6, R7)
    for (int k = 0; k < 17; k++) begin
      if (k == 16) check("R3 wrap", t_o, 32'h1);
      else         check("R2 slot", t_o, 32'h1 << k);
      if (k % 16 == 0) begin
        check("R5 sel", sel, 3'b010);
        check("R5 bus", bus_o, {4'h0, exp_pc});
        check("R5 ctl", {ar_ld, ir_ld, mem_rd, pc_inc}, 4'b1000);
      end else if (k == 1) begin
        check("R5 ar", ar_o, exp_pc);
        check("R6 sel", sel, 3'b111);
        check("R6 bus", bus_o, mem);
        check("R6 ctl", {ar_ld, ir_ld, mem_rd, pc_inc}, 4'b0111);
      end else begin
        ctl_idle("R7 ctl");
        if (k == 2) begin
          exp_pc = exp_pc + 1'b1;
          exp_ir = mem;
          check("R6 ir", ir_o, exp_ir);
          check("R6 pc", pc_o, exp_pc);
        end else begin
          check("R7 pc hold", pc_o, exp_pc);
          check("R7 ir hold", ir_o, exp_ir);
        end
      end
      @(negedge clk);
    end
    // now in slot 1: clear must beat the increment (R4)
    sc_clr = 1'b1;
    @(negedge clk);
    sc_clr = 1'b0;
    exp_pc = exp_pc + 1'b1;
    check("R4 clr in T1", t_o, 32'h1);

    // clear in slot 0 keeps slot 0 (R4)
    sc_clr = 1'b1;
    @(negedge clk);
    sc_clr = 1'b0;
    check("R4 clr in T0", t_o, 32'h1);
    check("R4 no fetch", pc_o, exp_pc);

    // clear in slot 5
    repeat (5) @(negedge clk);
    exp_pc = exp_pc + 1'b1;
    check("R2 slot5", t_o, 32'h20);
    sc_clr = 1'b1;
    @(negedge clk);
    sc_clr = 1'b0;
    check("R4 clr in T5", t_o, 32'h1);

    // vector table: one fetch per word (R6, R8, R9)
    for (int v = 0; v < 8; v++) begin
      mem = VEC[v][36:21];
      check("R5 ar_ld", ar_ld, 1'b1);
      @(negedge clk);
      check("R5 ar", ar_o, exp_pc);
      sc_clr = 1'b1;
      @(negedge clk);
      sc_clr = 1'b0;
      exp_pc = exp_pc + 1'b1;
      check("R6 ir", ir_o, VEC[v][36:21]);
      check("R6 pc", pc_o, exp_pc);
      check("R8 d", d_o, VEC[v][20:13]);
      check("R9 ind", ind_o, VEC[v][12]);
      check("R9 addr", addr_o, VEC[v][11:0]);
    end

    // program counter wrap (R10)
    while (exp_pc != 12'hFFF) begin
      @(negedge clk);
      sc_clr = 1'b1;
      @(negedge clk);
      sc_clr = 1'b0;
      exp_pc = exp_pc + 1'b1;
    end
    check("R10 pc max", pc_o, 12'hFFF);
    @(negedge clk);
    sc_clr = 1'b1;
    @(negedge clk);
    sc_clr = 1'b0;
    check("R10 pc wrap", pc_o, 12'h000);

    // asynchronous reset mid-instruction (R1)
    mem = 16'h7777;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async t", t_o, 32'h1);
    check("R1 async pc", pc_o, 0);
    check("R1 async ir", ir_o, 0);
    check("R1 async ar", ar_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
  end
endmodule